// File: doc/BRIEF.md
# Low-Power Wait Sequencer

This block takes a small CPU core into a low-power wait state and brings it back out. A one-cycle wait request from instruction decode puts the sequencer in its sleeping state. There it drops the CPU clock enable, keeps the peripheral clock enable high, and holds the bus address at the location that follows the wait opcode. Each interrupt source has a request bit and an enable bit, and only an enabled request wakes the core.

An interrupt wake starts exception stacking on the next cycle. Stacking is five byte writes to descending stack addresses, followed by a done pulse. A reset wake comes from the external synchronous reset, or from a watchdog timeout when the watchdog is enabled. It enters a recovery phase that holds the core for a fixed count and then issues two strobes in turn: one fetching the reset vector high byte, then one fetching the low byte.

The states are:

- RUN: the core executes.
- SLEEP: clocks are gated.
- PUSH: stacking is in progress.
- RECOVER: the reset hold-off.
- VEC_HI: fetch of the vector high byte.
- VEC_LO: fetch of the vector low byte.

The transitions are:

- RUN to SLEEP on a wait request with no enabled interrupt.
- RUN to PUSH on a wait request while an enabled interrupt is pending.
- SLEEP to PUSH on an enabled interrupt.
- PUSH to RUN after the fifth write.
- RECOVER to VEC_HI when the hold-off expires.
- VEC_HI to VEC_LO, then VEC_LO to RUN.
- Any state to RECOVER on an internal reset.

Top module: `wait_seq_ctrl`

## Requirements
- R1: In SLEEP, `cpu_clk_en` is 0 and `per_clk_en` is 1.
- R2: On entry to SLEEP, `hold_addr` captures `wait_next_addr`. `bus_freeze` is 1 throughout SLEEP, and `hold_addr` does not change while SLEEP lasts, even if `wait_next_addr` changes.
- R3: A request bit `irq_req[i]` whose matching `irq_en[i]` is 0 does not end SLEEP. `cpu_clk_en` stays 0 and no stack write occurs.
- R4: If an enabled request (`irq_req[i] & irq_en[i]`) is sampled in a SLEEP cycle, the first stack write appears in the very next cycle.
- R5: An interrupt wake makes exactly five consecutive stack writes (`stack_we` = 1). The addresses are 0x00FF, 0x00FE, 0x00FD, 0x00FC and 0x00FB. `stack_sel` takes the values 0 = PC low, 1 = PC high, 2 = index, 3 = accumulator, 4 = condition codes, in that order.
- R6: `stack_done` is high for exactly one cycle, in the cycle after the fifth stack write, and the core is then in RUN.
- R7: A `wdog_timeout` while `wdog_dis` = 0 forces recovery from any state, including SLEEP. While `wdog_dis` = 1, `wdog_timeout` has no effect.
- R8: Recovery keeps `rec_busy` = 1 and `cpu_clk_en` = 0 for 64 cycles, counted from the last cycle in which a reset was sampled. `vec_hi_fetch` then pulses for one cycle, followed at once by a one-cycle `vec_lo_fetch`, after which the block is in RUN.
- R9: If an enabled interrupt and an enabled watchdog timeout are sampled in the same cycle, the block enters recovery and makes no stack write.
- R10: A wait request made while an enabled interrupt is already pending does not gate `cpu_clk_en`. The first stack write appears in the next cycle.
- R11: Synchronous active-high `rst` puts the block in recovery with the count cleared: `rec_busy` = 1, `cpu_clk_en` = 0, `stack_we` = 0. Asserting `rst` again during recovery restarts the 64-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts recovery |
| wait_req | input | 1 | One-cycle wait request from instruction decode |
| wait_next_addr | input | ADDR_W | Address following the wait opcode |
| irq_req | input | NUM_IRQ | Per-source interrupt requests |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| wdog_dis | input | 1 | Watchdog disable configuration bit (1 = disabled) |
| wdog_timeout | input | 1 | Watchdog timeout |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| bus_freeze | output | 1 | Address bus held |
| hold_addr | output | ADDR_W | Held bus address |
| stack_we | output | 1 | Stack write strobe |
| stack_addr | output | ADDR_W | Stack write address |
| stack_sel | output | 3 | Byte being stacked |
| stack_done | output | 1 | Stacking finished pulse |
| rec_busy | output | 1 | Reset recovery in progress |
| vec_hi_fetch | output | 1 | Reset vector high byte fetch |
| vec_lo_fetch | output | 1 | Reset vector low byte fetch |

## Verification
An interrupt wake and a reset wake can arrive in the same cycle. The bench provokes this by raising an enabled request and an enabled watchdog timeout on the same sleeping edge. It judges the outcome through a scoreboard that expects no stack write, and expects the high and low vector fetches exactly 64 and 65 cycles later. The second overlap is a wait request that coincides with a pending enabled interrupt: the clock enable must stay high and the first push must land on the next cycle.

// File: rtl/wait_seq_pkg.sv
package wait_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_PUSH,
        ST_RECOVER,
        ST_VEC_HI,
        ST_VEC_LO
    } wseq_state_t;

    // order in which the context bytes are pushed
    typedef enum logic [2:0] {
        SB_PCL = 3'd0,
        SB_PCH = 3'd1,
        SB_IDX = 3'd2,
        SB_ACC = 3'd3,
        SB_CCR = 3'd4
    } wseq_byte_t;

    localparam int unsigned STACK_BYTES = 5;

endpackage

// File: rtl/wseq_irq_detect.sv
module wseq_irq_detect #(
    parameter int unsigned NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               wake_hit
);

    logic [NUM_IRQ-1:0] live;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        assign live[i] = irq_req[i] & irq_en[i];
    end

    assign wake_hit = |live;

endmodule

// File: rtl/wseq_counter.sv
module wseq_counter #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wait_seq_ctrl.sv
module wait_seq_ctrl
    import wait_seq_pkg::*;
#(
    parameter int unsigned       ADDR_W         = 16,
    parameter int unsigned       NUM_IRQ        = 8,
    parameter int unsigned       RECOVER_CYCLES = 64,
    parameter logic [ADDR_W-1:0] STACK_TOP      = 16'h00FF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wait_req,
    input  logic [ADDR_W-1:0]  wait_next_addr,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               wdog_dis,
    input  logic               wdog_timeout,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               bus_freeze,
    output logic [ADDR_W-1:0]  hold_addr,
    output logic               stack_we,
    output logic [ADDR_W-1:0]  stack_addr,
    output logic [2:0]         stack_sel,
    output logic               stack_done,
    output logic               rec_busy,
    output logic               vec_hi_fetch,
    output logic               vec_lo_fetch
);

    localparam int unsigned MAX_SPAN = (RECOVER_CYCLES > STACK_BYTES) ? RECOVER_CYCLES : STACK_BYTES;
    localparam int unsigned CNT_W    = (MAX_SPAN > 2) ? $clog2(MAX_SPAN) : 1;
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(RECOVER_CYCLES - 1);
    localparam logic [CNT_W-1:0] PUSH_LAST = CNT_W'(STACK_BYTES - 1);

    wseq_state_t       state_q, state_n;
    logic              wake_hit;
    logic              int_rst;
    logic              cnt_clr;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] hold_q;
    logic              done_q;

    wseq_irq_detect #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .wake_hit (wake_hit)
    );

    // watchdog is only a reset source when not disabled by configuration
    assign int_rst = wdog_timeout & ~wdog_dis;
    assign cnt_clr = int_rst | (state_n != state_q);

    wseq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .count (cnt)
    );

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN:     if (wait_req) state_n = wake_hit ? ST_PUSH : ST_SLEEP;
            ST_SLEEP:   if (wake_hit) state_n = ST_PUSH;
            ST_PUSH:    if (cnt == PUSH_LAST) state_n = ST_RUN;
            ST_RECOVER: if (cnt == REC_LAST) state_n = ST_VEC_HI;
            ST_VEC_HI:  state_n = ST_VEC_LO;
            ST_VEC_LO:  state_n = ST_RUN;
            default:    state_n = ST_RECOVER;
        endcase
        if (int_rst) begin
            state_n = ST_RECOVER;
        end
    end

    // state register, held address and done flag
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RECOVER;
            hold_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            done_q  <= (state_q == ST_PUSH) && (cnt == PUSH_LAST) && !int_rst;
            if (state_q == ST_RUN && state_n == ST_SLEEP) begin
                hold_q <= wait_next_addr;
            end
        end
    end

    // outputs decoded from the state register only
    always_comb begin
        cpu_clk_en   = 1'b0;
        bus_freeze   = 1'b0;
        stack_we     = 1'b0;
        stack_addr   = STACK_TOP;
        stack_sel    = SB_PCL;
        rec_busy     = 1'b0;
        vec_hi_fetch = 1'b0;
        vec_lo_fetch = 1'b0;
        unique case (state_q)
            ST_RUN:     cpu_clk_en = 1'b1;
            ST_SLEEP:   bus_freeze = 1'b1;
            ST_PUSH: begin
                cpu_clk_en = 1'b1;
                stack_we   = 1'b1;
                stack_addr = STACK_TOP - ADDR_W'(cnt);
                stack_sel  = 3'(cnt);
            end
            ST_RECOVER: rec_busy = 1'b1;
            ST_VEC_HI: begin
                rec_busy     = 1'b1;
                vec_hi_fetch = 1'b1;
            end
            ST_VEC_LO: begin
                rec_busy     = 1'b1;
                vec_lo_fetch = 1'b1;
            end
            default:    rec_busy = 1'b1;
        endcase
    end

    assign per_clk_en = 1'b1;
    assign hold_addr  = hold_q;
    assign stack_done = done_q;

endmodule

// File: rtl/wait_seq_chk.sv
module wait_seq_chk
    import wait_seq_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STACK_TOP = 16'h00FF
) (
    input logic              clk,
    input logic              rst,
    input wseq_state_t       state_q,
    input logic              wake_hit,
    input logic              int_rst,
    input logic              wait_req,
    input logic              wdog_dis,
    input logic              wdog_timeout,
    input logic              cpu_clk_en,
    input logic              per_clk_en,
    input logic [ADDR_W-1:0] hold_addr,
    input logic              stack_we,
    input logic [ADDR_W-1:0] stack_addr,
    input logic [2:0]        stack_sel,
    input logic              stack_done,
    input logic              rec_busy,
    input logic              vec_hi_fetch,
    input logic              vec_lo_fetch
);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    assert_sleep_gates_cpu_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP) |-> (!cpu_clk_en && per_clk_en));

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (seen && state_q == ST_SLEEP && $past(state_q) == ST_SLEEP) |-> $stable(hold_addr));

    assert_masked_stays_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && !wake_hit && !int_rst) |=> (state_q == ST_SLEEP));

    assert_push_after_wake_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && wake_hit && !int_rst) |=>
            (stack_we && stack_addr == STACK_TOP && stack_sel == 3'd0));

    assert_stack_descend_R5: assert property (@(posedge clk) disable iff (rst)
        (seen && stack_we && $past(stack_we)) |->
            (stack_addr == $past(stack_addr) - ADDR_W'(1)));

    assert_single_event_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stack_we, stack_done, vec_hi_fetch, vec_lo_fetch}));

    assert_done_follows_R6: assert property (@(posedge clk) disable iff (rst)
        stack_done |-> (seen && $past(stack_we) && $past(stack_sel) == 3'd4));

    assert_wdog_reset_R7: assert property (@(posedge clk) disable iff (rst)
        (wdog_timeout && !wdog_dis) |=> (rec_busy && !cpu_clk_en));

    assert_lo_after_hi_R8: assert property (@(posedge clk) disable iff (rst)
        vec_lo_fetch |-> (seen && $past(vec_hi_fetch)));

    assert_reset_wins_R9: assert property (@(posedge clk) disable iff (rst)
        int_rst |=> (rec_busy && !stack_we));

    assert_pending_no_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && wait_req && wake_hit && !int_rst) |=> (stack_we && cpu_clk_en));

endmodule

bind wait_seq_ctrl wait_seq_chk #(
    .ADDR_W    (ADDR_W),
    .STACK_TOP (STACK_TOP)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .state_q      (state_q),
    .wake_hit     (wake_hit),
    .int_rst      (int_rst),
    .wait_req     (wait_req),
    .wdog_dis     (wdog_dis),
    .wdog_timeout (wdog_timeout),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .hold_addr    (hold_addr),
    .stack_we     (stack_we),
    .stack_addr   (stack_addr),
    .stack_sel    (stack_sel),
    .stack_done   (stack_done),
    .rec_busy     (rec_busy),
    .vec_hi_fetch (vec_hi_fetch),
    .vec_lo_fetch (vec_lo_fetch)
);

// File: tb/wait_seq_ctrl_tb.sv
module wait_seq_ctrl_tb;

    localparam int ADDR_W = 16;
    localparam int NIRQ   = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wait_req = 1'b0;
    logic [ADDR_W-1:0] wait_next_addr = '0;
    logic [NIRQ-1:0]   irq_req = '0;
    logic [NIRQ-1:0]   irq_en = '0;
    logic              wdog_dis = 1'b1;
    logic              wdog_timeout = 1'b0;
    logic              cpu_clk_en, per_clk_en, bus_freeze;
    logic [ADDR_W-1:0] hold_addr, stack_addr;
    logic              stack_we, stack_done, rec_busy, vec_hi_fetch, vec_lo_fetch;
    logic [2:0]        stack_sel;

    wait_seq_ctrl #(.ADDR_W(ADDR_W), .NUM_IRQ(NIRQ)) u_dut (
        .clk(clk), .rst(rst), .wait_req(wait_req), .wait_next_addr(wait_next_addr),
        .irq_req(irq_req), .irq_en(irq_en), .wdog_dis(wdog_dis), .wdog_timeout(wdog_timeout),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .bus_freeze(bus_freeze),
        .hold_addr(hold_addr), .stack_we(stack_we), .stack_addr(stack_addr),
        .stack_sel(stack_sel), .stack_done(stack_done), .rec_busy(rec_busy),
        .vec_hi_fetch(vec_hi_fetch), .vec_lo_fetch(vec_lo_fetch)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;

    // event kinds: 0 push, 1 done, 2 vector high, 3 vector low
    typedef struct {
        int    kind;
        int    at;
        int    addr;
        int    sel;
        string req;
    } ev_t;
    ev_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push_ev(input int kind, input int at, input int addr, input int sel, input string req);
        ev_t e;
        e.kind = kind; e.at = at; e.addr = addr; e.sel = sel; e.req = req;
        exp_q.push_back(e);
    endtask

    // R4 R5 R6: five pushes from 0x00FF downward, then done
    task automatic expect_stack(input int first, input string req);
        for (int i = 0; i < 5; i++) push_ev(0, first + i, 'h00FF - i, i, req);
        push_ev(1, first + 5, 0, 0, "R6");
    endtask

    // R8: reset last sampled at edge p, vector fetches 64 and 65 later
    task automatic expect_recovery(input int p, input string req);
        push_ev(2, p + 64, 0, 0, req);
        push_ev(3, p + 65, 0, 0, req);
    endtask

    task automatic nxt();
        @(negedge clk);
        #2;
    endtask

    task automatic wait_run();
        while (rec_busy) nxt();
    endtask

    task automatic enter_sleep(input logic [ADDR_W-1:0] a);
        wait_req = 1'b1;
        wait_next_addr = a;
        nxt();
        wait_req = 1'b0;
    endtask

    // monitor: pops the scoreboard as events appear
    always @(negedge clk) begin
        int  k;
        ev_t e;
        k = -1;
        if (stack_we)          k = 0;
        else if (stack_done)   k = 1;
        else if (vec_hi_fetch) k = 2;
        else if (vec_lo_fetch) k = 3;
        if (exp_q.size() > 0 && exp_q[0].at < cyc) begin
            e = exp_q.pop_front();
            chk(1'b0, e.req, "missing event kind", -1, e.kind);
        end
        if (k >= 0) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected event kind", k, -1);
            end else begin
                e = exp_q.pop_front();
                chk(e.kind == k, e.req, "event kind", k, e.kind);
                chk(e.at == cyc, e.req, "event cycle", cyc, e.at);
                if (k == 0) begin
                    chk(e.addr == int'(stack_addr), e.req, "stack address", int'(stack_addr), e.addr);
                    chk(e.sel == int'(stack_sel), "R5", "stack byte select", int'(stack_sel), e.sel);
                end
            end
        end
    end

    initial begin
        int t;
        repeat (3) nxt();
        // R11 reset state
        chk(rec_busy == 1'b1, "R11", "rec_busy in reset", rec_busy, 1);
        chk(cpu_clk_en == 1'b0, "R11", "cpu_clk_en in reset", cpu_clk_en, 0);
        chk(stack_we == 1'b0, "R11", "stack_we in reset", stack_we, 0);
        rst = 1'b0;
        expect_recovery(cyc, "R8");
        wait_run();
        chk(cpu_clk_en == 1'b1, "R8", "running after recovery", cpu_clk_en, 1);

        // interrupt wake from sleep
        enter_sleep(16'hDE0C);
        chk(cpu_clk_en == 1'b0, "R1", "cpu_clk_en in sleep", cpu_clk_en, 0);
        chk(per_clk_en == 1'b1, "R1", "per_clk_en in sleep", per_clk_en, 1);
        chk(bus_freeze == 1'b1, "R2", "bus_freeze in sleep", bus_freeze, 1);
        chk(hold_addr == 16'hDE0C, "R2", "held address", int'(hold_addr), 'hDE0C);
        wait_next_addr = 16'h1234;
        nxt(); nxt();
        chk(hold_addr == 16'hDE0C, "R2", "held address stable", int'(hold_addr), 'hDE0C);
        irq_req = 8'h04; irq_en = 8'h04;
        expect_stack(cyc + 1, "R4");
        nxt();
        irq_req = '0;
        chk(stack_we == 1'b1, "R4", "push next cycle", stack_we, 1);
        repeat (6) nxt();

        // masked request and disabled watchdog leave the core asleep
        enter_sleep(16'h0040);
        irq_req = 8'h01; irq_en = 8'h82;
        wdog_dis = 1'b1; wdog_timeout = 1'b1;
        repeat (5) nxt();
        chk(cpu_clk_en == 1'b0, "R3", "masked request keeps sleep", cpu_clk_en, 1'b0);
        chk(stack_we == 1'b0, "R3", "no stacking when masked", stack_we, 0);
        chk(rec_busy == 1'b0, "R7", "disabled watchdog ignored", rec_busy, 0);
        wdog_timeout = 1'b0;
        irq_req = '0;
        // enabled watchdog ends sleep
        wdog_dis = 1'b0; wdog_timeout = 1'b1;
        expect_recovery(cyc + 1, "R7");
        nxt();
        wdog_timeout = 1'b0;
        chk(rec_busy == 1'b1, "R7", "watchdog starts recovery", rec_busy, 1);
        wait_run();

        // wake source of the highest index
        enter_sleep(16'h0100);
        irq_req = 8'h80;
        expect_stack(cyc + 1, "R5");
        nxt();
        irq_req = '0;
        repeat (6) nxt();

        // same-cycle interrupt and watchdog: reset wins
        enter_sleep(16'h0200);
        irq_req = 8'h02; irq_en = 8'h02; wdog_timeout = 1'b1;
        expect_recovery(cyc + 1, "R9");
        nxt();
        irq_req = '0; wdog_timeout = 1'b0;
        chk(stack_we == 1'b0, "R9", "no push on reset priority", stack_we, 0);
        chk(rec_busy == 1'b1, "R9", "recovery on reset priority", rec_busy, 1);
        wait_run();

        // wait request while enabled interrupt already pending
        irq_req = 8'h02; irq_en = 8'h02; wait_req = 1'b1;
        expect_stack(cyc + 1, "R10");
        nxt();
        irq_req = '0; wait_req = 1'b0;
        chk(cpu_clk_en == 1'b1, "R10", "clock not gated", cpu_clk_en, 1);
        repeat (6) nxt();

        // reset reasserted during recovery restarts the count
        rst = 1'b1;
        nxt();
        rst = 1'b0;
        repeat (30) nxt();
        rst = 1'b1;
        nxt();
        rst = 1'b0;
        t = cyc;
        expect_recovery(t, "R11");
        chk(rec_busy == 1'b1, "R11", "recovery after second reset", rec_busy, 1);
        wait_run();

        repeat (3) nxt();
        chk(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule